// File: doc/BRIEF.md
# Staged SPI Configuration Register Bank

This block is the byte-wide control register file of a data converter. A host reaches it through a four-wire SPI slave port (mode 0). The output enable on the data-out line lets the port share one bidirectional wire in a three-wire arrangement. Each transaction opens with a 16-bit instruction word: a direction flag, a byte-count field and a 13-bit start address. One or more data bytes follow.

The bank has three kinds of register. The port-setup register acts at once. The identification registers are read-only. Function registers (power mode and over-range enable) are written into a staging copy, and they reach the live copy only when the host sets a commit bit. The commit bit clears itself. The decoded power state and the over-range enable are driven from the live copy. An external power-down pin can override the programmed power mode. The host can change the shift order to least-significant-bit first, or issue a soft reset that reloads every default.

Top module: `cfg_bank`

## Requirements
- R1: Address 0x00 reads 0x18 after reset. Bits 4 and 3 always read 1 and bits 7 and 0 always read 0. LSB-first order is the OR of bits 6 and 1. Soft reset is the OR of bits 5 and 2, so the register decodes the same whichever way the host shifts it. A write to 0x00 takes effect without a commit.
- R2: Address 0x01 reads the chip identifier 0x6C. Address 0x02 reads 0x00, with the grade field in bits 5:4 equal to 00. Writes to either address are ignored.
- R3: The instruction is 16 bits. Bit 15 is 1 for a read and 0 for a write. Bits 14:13 give the byte count (00 one, 01 two, 10 three, 11 continue until chip select rises). Bits 12:0 give the address. Bits are sampled on the rising clock edge, read data changes on the falling edge, and the default order is MSB first. spi_miso_oe is high only during the data phase of a read while chip select is low.
- R4: After each data byte the address steps up by one in MSB-first order and down by one in LSB-first order. In LSB-first order the instruction word and every data byte are shifted least significant bit first. The order in force is taken from address 0x00 when chip select falls.
- R5: Writes to 0x08 and 0x2A go to the staging copy only. Reads of those addresses, and the outputs, follow the live copy. Writing 1 to bit 0 of 0xFF copies every staged value into the live copy one clock later. The bit then clears itself, so a later read of 0xFF returns 0x00.
- R6: Bits 2:0 of the live 0x08 value select the power state: 001 gives full power-down (pwr_state 01), 010 gives standby (pwr_state 10), and every other code gives normal (pwr_state 00).
- R7: While ext_pd is high it overrides R6. Live bit 5 of 0x08 then selects full power-down (0) or standby (1).
- R8: ovr_en follows live bit 0 of 0x2A, whose default is 1.
- R9: A soft reset loads the defaults into the staging copy, the live copy and address 0x00, and then clears itself. Afterwards 0x00 reads 0x18 again and MSB-first order is back in force.
- R10: Reserved bits read 0. Address 0x08 keeps only bits 5 and 2:0, and 0x2A keeps only bit 0. Unmapped addresses read 0x00, and writes to them have no effect.
- R11: While rst is high, and after it falls, pwr_state is 00, ovr_en is 1 and spi_miso_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SPI lines are oversampled with it |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock |
| spi_csn | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial read data to host |
| spi_miso_oe | output | 1 | Drive enable for spi_miso |
| ext_pd | input | 1 | External power-down request, active high |
| pwr_state | output | 2 | 00 normal, 01 full power-down, 10 standby |
| ovr_en | output | 1 | Over-range output enable |

## Verification
A staging copy that leaks into the live copy shows up as pwr_state or ovr_en changing right after a write that carried no commit. The same fault makes a read-back of 0x08 or 0x2A return the new value early, one transaction before it should. A stuck commit bit or soft reset is seen on the next read of 0xFF or 0x00. A wrong address-step direction or shift order corrupts the second byte of a multi-byte read at once. A broken override path shows on pwr_state within a few clocks of ext_pd changing.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  typedef enum logic [1:0] {
    PWR_ON   = 2'b00,
    PWR_OFF  = 2'b01,
    PWR_STBY = 2'b10
  } pwr_e;

  localparam int unsigned ADR_PORT  = 'h000;
  localparam int unsigned ADR_ID    = 'h001;
  localparam int unsigned ADR_GRADE = 'h002;
  localparam int unsigned ADR_MODE  = 'h008;
  localparam int unsigned ADR_OVR   = 'h02A;
  localparam int unsigned ADR_XFER  = 'h0FF;
endpackage

// File: rtl/cfg_spi_port.sv
module cfg_spi_port #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              csn,
  input  logic              mosi,
  input  logic              lsb_cfg,
  output logic              miso,
  output logic              miso_oe,
  output logic              cs_live,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data
);
  localparam int IW = ADDR_W + 3;
  localparam int CW = $clog2(IW);

  typedef enum logic [1:0] {PH_IDLE, PH_INSTR, PH_DATA, PH_DONE} phase_e;

  logic [SYNC_N:0]   sclk_p, csn_p;
  logic [SYNC_N-1:0] mosi_p;
  logic rise, fall, cs_start, mosi_s;

  phase_e            phase;
  logic [IW-1:0]     sr, sr_nxt;
  logic [CW-1:0]     bcnt;
  logic              rd_q, lsb_q, load_q;
  logic [1:0]        cnt_q, bytes_q;
  logic [ADDR_W-1:0] addr_q, step;
  logic [DATA_W-1:0] tx_q, byte_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_p <= '0;
      csn_p  <= '1;
      mosi_p <= '0;
    end else begin
      sclk_p <= {sclk_p[SYNC_N-1:0], sclk};
      csn_p  <= {csn_p[SYNC_N-1:0], csn};
      mosi_p <= {mosi_p[SYNC_N-2:0], mosi};
    end
  end

  assign rise     = sclk_p[SYNC_N-1] & ~sclk_p[SYNC_N];
  assign fall     = ~sclk_p[SYNC_N-1] & sclk_p[SYNC_N];
  assign cs_live  = ~csn_p[SYNC_N-1];
  assign cs_start = ~csn_p[SYNC_N-1] & csn_p[SYNC_N];
  assign mosi_s   = mosi_p[SYNC_N-1];

  assign sr_nxt   = lsb_q ? {mosi_s, sr[IW-1:1]} : {sr[IW-2:0], mosi_s};
  assign byte_nxt = lsb_q ? sr_nxt[IW-1 -: DATA_W] : sr_nxt[DATA_W-1:0];
  assign step     = lsb_q ? addr_q - 1'b1 : addr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      sr      <= '0;
      bcnt    <= '0;
      rd_q    <= 1'b0;
      lsb_q   <= 1'b0;
      load_q  <= 1'b0;
      cnt_q   <= '0;
      bytes_q <= '0;
      addr_q  <= '0;
      tx_q    <= '0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en  <= 1'b0;
      load_q <= 1'b0;
      if (!cs_live) begin
        phase <= PH_IDLE;
        bcnt  <= '0;
      end else if (cs_start) begin
        phase   <= PH_INSTR;
        lsb_q   <= lsb_cfg;
        bcnt    <= '0;
        bytes_q <= '0;
      end else if (rise) begin
        case (phase)
          PH_INSTR: begin
            sr <= sr_nxt;
            if (bcnt == CW'(IW - 1)) begin
              bcnt   <= '0;
              phase  <= PH_DATA;
              rd_q   <= sr_nxt[IW-1];
              cnt_q  <= sr_nxt[IW-2 -: 2];
              addr_q <= sr_nxt[ADDR_W-1:0];
              load_q <= sr_nxt[IW-1];
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          PH_DATA: begin
            sr <= sr_nxt;
            if (bcnt == CW'(DATA_W - 1)) begin
              bcnt    <= '0;
              addr_q  <= step;
              load_q  <= rd_q;
              bytes_q <= bytes_q + 1'b1;
              if (!rd_q) begin
                wr_en   <= 1'b1;
                wr_addr <= addr_q;
                wr_data <= byte_nxt;
              end
              if (cnt_q != 2'b11 && bytes_q == cnt_q) phase <= PH_DONE;
            end else begin
              bcnt <= bcnt + 1'b1;
            end
          end
          default: ;
        endcase
      end else if (fall && phase == PH_DATA && rd_q && bcnt != '0) begin
        tx_q <= lsb_q ? (tx_q >> 1) : (tx_q << 1);
      end
      if (load_q) tx_q <= rd_data;
    end
  end

  assign rd_addr = addr_q;
  assign miso    = lsb_q ? tx_q[0] : tx_q[DATA_W-1];
  assign miso_oe = cs_live && phase == PH_DATA && rd_q;
endmodule

// File: rtl/cfg_regs.sv
module cfg_regs
  import cfg_bank_pkg::*;
#(
  parameter int          ADDR_W  = 13,
  parameter int          DATA_W  = 8,
  parameter logic [7:0]  CHIP_ID = 8'h6C,
  parameter logic [1:0]  GRADE   = 2'b00
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              lsb_first,
  output logic              soft_rst,
  output logic              xfer_pend,
  output logic [3:0]        act_mode,
  output logic              act_ovr
);
  localparam logic [ADDR_W-1:0] AP = ADDR_W'(ADR_PORT);
  localparam logic [ADDR_W-1:0] AI = ADDR_W'(ADR_ID);
  localparam logic [ADDR_W-1:0] AG = ADDR_W'(ADR_GRADE);
  localparam logic [ADDR_W-1:0] AM = ADDR_W'(ADR_MODE);
  localparam logic [ADDR_W-1:0] AO = ADDR_W'(ADR_OVR);
  localparam logic [ADDR_W-1:0] AX = ADDR_W'(ADR_XFER);

  // port_q = {bit6 lsb, bit5 srst, bit2 srst, bit1 lsb}
  logic [3:0] port_q;
  logic [3:0] sh_mode;
  logic       sh_ovr;
  wire        unused_wbits = ^{wr_data[DATA_W-1:7], wr_data[4:3]};

  assign lsb_first = port_q[3] | port_q[0];
  assign soft_rst  = port_q[2] | port_q[1];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      port_q    <= '0;
      sh_mode   <= '0;
      act_mode  <= '0;
      sh_ovr    <= 1'b1;
      act_ovr   <= 1'b1;
      xfer_pend <= 1'b0;
    end else begin
      if (xfer_pend) begin
        act_mode  <= sh_mode;
        act_ovr   <= sh_ovr;
        xfer_pend <= 1'b0;
      end
      if (wr_en) begin
        case (wr_addr)
          AP: port_q    <= {wr_data[6], wr_data[5], wr_data[2], wr_data[1]};
          AM: sh_mode   <= {wr_data[5], wr_data[2:0]};
          AO: sh_ovr    <= wr_data[0];
          AX: xfer_pend <= wr_data[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      AP: rd_data[7:0] = {1'b0, port_q[3], port_q[2], 2'b11, port_q[1], port_q[0], 1'b0};
      AI: rd_data[7:0] = CHIP_ID;
      AG: rd_data[5:4] = GRADE;
      AM: begin
        rd_data[5]   = act_mode[3];
        rd_data[2:0] = act_mode[2:0];
      end
      AO: rd_data[0] = act_ovr;
      AX: rd_data[0] = xfer_pend;
      default: ;
    endcase
  end
endmodule

// File: rtl/cfg_pwr_ctl.sv
module cfg_pwr_ctl
  import cfg_bank_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ext_pd,
  input  logic [3:0] act_mode,
  input  logic       act_ovr,
  output logic [1:0] pwr_state,
  output logic       ovr_en
);
  logic [SYNC_N-1:0] pd_sync;
  pwr_e              pwr_q, pwr_nxt;

  always_comb begin
    if (pd_sync[SYNC_N-1]) begin
      pwr_nxt = act_mode[3] ? PWR_STBY : PWR_OFF;
    end else begin
      case (act_mode[2:0])
        3'b001:  pwr_nxt = PWR_OFF;
        3'b010:  pwr_nxt = PWR_STBY;
        default: pwr_nxt = PWR_ON;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_sync <= '0;
      pwr_q   <= PWR_ON;
      ovr_en  <= 1'b1;
    end else begin
      pd_sync <= {pd_sync[SYNC_N-2:0], ext_pd};
      pwr_q   <= pwr_nxt;
      ovr_en  <= act_ovr;
    end
  end

  assign pwr_state = pwr_q;
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int         ADDR_W  = 13,
  parameter int         DATA_W  = 8,
  parameter int         SYNC_N  = 2,
  parameter logic [7:0] CHIP_ID = 8'h6C,
  parameter logic [1:0] GRADE   = 2'b00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spi_sclk,
  input  logic       spi_csn,
  input  logic       spi_mosi,
  output logic       spi_miso,
  output logic       spi_miso_oe,
  input  logic       ext_pd,
  output logic [1:0] pwr_state,
  output logic       ovr_en
);
  logic              wr_en, lsb_first, soft_rst, xfer_pend, act_ovr, cs_live;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [3:0]        act_mode;

  cfg_spi_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_spi (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .csn(spi_csn), .mosi(spi_mosi),
    .lsb_cfg(lsb_first), .miso(spi_miso), .miso_oe(spi_miso_oe), .cs_live(cs_live),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHIP_ID(CHIP_ID), .GRADE(GRADE)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lsb_first(lsb_first),
    .soft_rst(soft_rst), .xfer_pend(xfer_pend), .act_mode(act_mode), .act_ovr(act_ovr)
  );

  cfg_pwr_ctl #(.SYNC_N(SYNC_N)) u_pwr (
    .clk(clk), .rst(rst), .ext_pd(ext_pd), .act_mode(act_mode), .act_ovr(act_ovr),
    .pwr_state(pwr_state), .ovr_en(ovr_en)
  );
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk #(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8,
  parameter int SYNC_N = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_live,
  input logic              miso_oe,
  input logic              ext_pd,
  input logic [1:0]        pwr_state,
  input logic              xfer_pend,
  input logic              soft_rst,
  input logic [3:0]        act_mode,
  input logic              act_ovr,
  input logic              lsb_first,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [DATA_W-1:0] rd_data
);
  logic [3:0] pd_hi, pd_lo;
  logic       mapped;

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_hi <= '0;
      pd_lo <= '0;
    end else begin
      pd_hi <= ext_pd  ? (pd_hi == 4'hF ? pd_hi : pd_hi + 1'b1) : '0;
      pd_lo <= !ext_pd ? (pd_lo == 4'hF ? pd_lo : pd_lo + 1'b1) : '0;
    end
  end

  assign mapped = rd_addr inside {ADDR_W'('h000), ADDR_W'('h001), ADDR_W'('h002),
                                  ADDR_W'('h008), ADDR_W'('h02A), ADDR_W'('h0FF)};

  // R3: no drive on the data line once chip select is seen high
  assert_oe_idle_R3: assert property (@(posedge clk) disable iff (rst)
    !cs_live |=> !miso_oe);

  // R5: live copy moves only on a commit or a soft reset
  assert_live_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!xfer_pend && !soft_rst) |=> ($stable(act_mode) && $stable(act_ovr)));

  // R6: full power-down code reaches the pin state when the override is idle
  assert_pd_code_R6: assert property (@(posedge clk) disable iff (rst)
    (pd_lo > 4'(SYNC_N) && act_mode[2:0] == 3'b001) |=> (pwr_state == 2'b01));

  // R7: a held override never leaves the state at normal
  assert_pin_override_R7: assert property (@(posedge clk) disable iff (rst)
    (pd_hi > 4'(SYNC_N)) |-> (pwr_state != 2'b00));

  // R9: soft reset restores defaults on the next cycle
  assert_soft_defaults_R9: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (act_ovr && act_mode == 4'h0 && !lsb_first && !soft_rst));

  // R10: unmapped addresses read as zero
  assert_hole_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !mapped |-> (rd_data == '0));
endmodule

bind cfg_bank cfg_bank_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_N(SYNC_N)) u_chk (
  .clk(clk), .rst(rst), .cs_live(cs_live), .miso_oe(spi_miso_oe), .ext_pd(ext_pd),
  .pwr_state(pwr_state), .xfer_pend(xfer_pend), .soft_rst(soft_rst),
  .act_mode(act_mode), .act_ovr(act_ovr), .lsb_first(lsb_first),
  .rd_addr(rd_addr), .rd_data(rd_data)
);

// File: tb/sim_cfg_bank.sv
`timescale 1ns/1ps
module sim_cfg_bank;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0, ext_pd = 1'b0;
  logic miso, oe, ovr;
  logic [1:0] pwr;

  int total = 0;
  int bad = 0;
  bit lsb_mode = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2.5 clk = ~clk;

  cfg_bank u0 (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_csn(csn), .spi_mosi(mosi),
    .spi_miso(miso), .spi_miso_oe(oe), .ext_pd(ext_pd),
    .pwr_state(pwr), .ovr_en(ovr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic pulse();
    half(); sclk = 1'b1; half(); sclk = 1'b0;
  endtask

  task automatic spi(input bit rd, input bit [1:0] cnt, input bit [12:0] addr,
                     input int n, input logic [7:0] dat [4], input string tag);
    logic [15:0] w;
    w = {rd, cnt, addr};
    csn = 1'b0;
    half();
    for (int k = 0; k < 16; k++) begin
      mosi = lsb_mode ? w[k] : w[15-k];
      pulse();
    end
    for (int b = 0; b < n; b++) begin
      if (rd) begin
        exp_q.push_back(dat[b]);
        tag_q.push_back(tag);
      end
      for (int k = 0; k < 8; k++) begin
        mosi = rd ? 1'b0 : (lsb_mode ? dat[b][k] : dat[b][7-k]);
        pulse();
      end
    end
    half();
    csn = 1'b1;
    mosi = 1'b0;
    half(); half();
  endtask

  task automatic wr1(input bit [12:0] addr, input logic [7:0] d, input string tag);
    spi(1'b0, 2'b00, addr, 1, '{d, 8'h00, 8'h00, 8'h00}, tag);
  endtask

  task automatic rd1(input bit [12:0] addr, input logic [7:0] e, input string tag);
    spi(1'b1, 2'b00, addr, 1, '{e, 8'h00, 8'h00, 8'h00}, tag);
  endtask

  // monitor: gathers read bytes and scores them against the queue
  initial begin
    logic [7:0] acc;
    int nb;
    acc = '0;
    nb = 0;
    forever begin
      @(posedge sclk or posedge csn);
      if (csn) begin
        nb = 0;
      end else if (oe) begin
        acc = lsb_mode ? {miso, acc[7:1]} : {acc[6:0], miso};
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) begin
            check("R3 unexpected read byte", acc, 32'hFFFF);
          end else begin
            check(tag_q.pop_front(), acc, exp_q.pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R11 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (10) @(negedge clk);
    check("R11 reset pwr_state", pwr, 2'b00);
    check("R11 reset ovr_en", ovr, 1'b1);
    check("R11 reset miso_oe", oe, 1'b0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check("R11 after reset pwr_state", pwr, 2'b00);
    check("R11 after reset ovr_en", ovr, 1'b1);

    rd1(13'h000, 8'h18, "R1 port default");
    rd1(13'h001, 8'h6C, "R2 chip id");
    rd1(13'h002, 8'h00, "R2 grade");
    spi(1'b1, 2'b10, 13'h000, 3, '{8'h18, 8'h6C, 8'h00, 8'h00}, "R4 three byte increment");
    spi(1'b1, 2'b11, 13'h000, 4, '{8'h18, 8'h6C, 8'h00, 8'h00}, "R3 streaming read");

    wr1(13'h008, 8'h01, "R5 stage");
    rd1(13'h008, 8'h00, "R5 live unchanged before commit");
    check("R5 pwr before commit", pwr, 2'b00);
    wr1(13'h0FF, 8'h01, "R5 commit");
    check("R6 full power-down", pwr, 2'b01);
    rd1(13'h0FF, 8'h00, "R5 commit bit self-clears");
    rd1(13'h008, 8'h01, "R5 live after commit");

    wr1(13'h008, 8'h02, "R6 stage standby");
    wr1(13'h0FF, 8'h01, "R6 commit");
    check("R6 standby", pwr, 2'b10);
    wr1(13'h008, 8'h03, "R6 stage 011");
    wr1(13'h0FF, 8'h01, "R6 commit");
    check("R6 code 011 normal", pwr, 2'b00);
    wr1(13'h008, 8'hFF, "R10 stage all ones");
    wr1(13'h0FF, 8'h01, "R10 commit");
    rd1(13'h008, 8'h27, "R10 reserved bits of 0x08");
    check("R6 code 111 normal", pwr, 2'b00);

    ext_pd = 1'b1;
    repeat (8) @(negedge clk);
    check("R7 pin override standby select", pwr, 2'b10);
    wr1(13'h008, 8'h00, "R7 stage");
    wr1(13'h0FF, 8'h01, "R7 commit");
    check("R7 pin override full power-down", pwr, 2'b01);
    ext_pd = 1'b0;
    repeat (8) @(negedge clk);
    check("R7 pin released", pwr, 2'b00);

    wr1(13'h02A, 8'hFE, "R8 stage off");
    check("R8 ovr_en before commit", ovr, 1'b1);
    wr1(13'h0FF, 8'h01, "R8 commit");
    check("R8 ovr_en cleared", ovr, 1'b0);
    rd1(13'h02A, 8'h00, "R8 readback");
    wr1(13'h02A, 8'hFF, "R8 stage on");
    wr1(13'h0FF, 8'h01, "R8 commit");
    check("R8 ovr_en set", ovr, 1'b1);
    rd1(13'h02A, 8'h01, "R10 reserved bits of 0x2A");

    wr1(13'h001, 8'h00, "R2 write id");
    rd1(13'h001, 8'h6C, "R2 id unchanged");
    wr1(13'h002, 8'h30, "R2 write grade");
    rd1(13'h002, 8'h00, "R2 grade unchanged");
    wr1(13'h005, 8'hAA, "R10 write hole");
    rd1(13'h005, 8'h00, "R10 hole reads zero");

    wr1(13'h000, 8'h42, "R1 lsb-first on");
    lsb_mode = 1'b1;
    spi(1'b1, 2'b10, 13'h002, 3, '{8'h00, 8'h6C, 8'h5A, 8'h00}, "R4 lsb decrement read");
    spi(1'b0, 2'b01, 13'h008, 2, '{8'h02, 8'h99, 8'h00, 8'h00}, "R4 lsb decrement write");
    wr1(13'h0FF, 8'h01, "R4 commit in lsb");
    check("R4 lsb write reached 0x08", pwr, 2'b10);
    rd1(13'h008, 8'h02, "R4 lsb readback");

    wr1(13'h000, 8'h24, "R9 soft reset");
    lsb_mode = 1'b0;
    rd1(13'h000, 8'h18, "R9 port default again");
    rd1(13'h008, 8'h00, "R9 mode default");
    rd1(13'h02A, 8'h01, "R9 ovr default");
    check("R9 pwr after soft reset", pwr, 2'b00);
    check("R9 ovr_en after soft reset", ovr, 1'b1);

    wr1(13'h02A, 8'h00, "R11 stage");
    wr1(13'h0FF, 8'h01, "R11 commit");
    check("R11 ovr_en before hard reset", ovr, 1'b0);
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    check("R11 ovr_en after hard reset", ovr, 1'b1);
    rd1(13'h02A, 8'h01, "R11 0x2A after hard reset");

    repeat (20) @(negedge clk);
    check("R3 all read bytes seen", exp_q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule